// File: doc/BRIEF.md
# SPI Register Front End with Interrupt Control

This block is the bus-facing half of an SPI master. A host on a plain 32-bit read/write bus reaches a set of word registers: configuration, enable, inter-frame delay, idle count and transmit low-water level. Bytes written to the transmit data address enter a transmit FIFO. The shift engine drains that FIFO through a valid/ready stream. Bytes from the shift engine enter a receive FIFO, and reads of the receive data address pop them.

Interrupt state is held as a 7-bit word. Three of its bits are sticky event flags and four bits follow the live FIFO levels. The host changes the interrupt mask only through two write-only ports, one that sets bits and one that clears them. The mask can be read back at a separate address. One interrupt line is raised whenever a status bit and its mask bit are both one.

Back-pressure rules are as follows. The transmit stream moves a byte on any clock edge where `tx_valid` and `tx_ready` are both high, and `tx_data` holds steady while it waits. The shift engine raises `tx_ready` only when it needs the next byte. The receive stream cannot stall the engine: a beat with `rx_valid` high while `rx_ready` is low is lost and recorded as an overflow.

Top module: `spi_regfile_irq`

## Requirements
- R1: After reset the mask is 0, status reads 0x04 (transmit FIFO below the watermark), the watermark reads 1 and `irq` is low.
- R2: Word address index = `bus_addr[5:2]`: 0 configuration, 1 status, 2 mask-set, 3 mask-clear, 4 mask view, 5 enable (bit 0), 6 delay, 7 TX data, 8 RX data, 9 idle count (8 bits), 10 watermark (8 bits). Configuration, enable, delay, idle count and watermark read back what was written. A read strobe puts data on `bus_rdata` at the next clock edge, and the value holds until the next read. Reads of indices 2, 3 and 7 and of unmapped indices return 0.
- R3: Writing index 2 sets the mask bits where the write data has ones. Writing index 3 clears those bits. Zero bits leave the mask unchanged. Index 4 returns the 7-bit mask.
- R4: Status bits are: 0 RX overflow, 1 mode fault, 2 TX below watermark, 3 TX full, 4 RX not empty, 5 RX full, 6 TX underflow. Writing ones to index 1 clears the sticky bits 0, 1 and 6. An event in the same cycle as its clear leaves the bit set. Writes to bits 2 to 5 have no effect.
- R5: `irq` is high exactly when (status AND mask) is nonzero, with no added delay.
- R6: Each write to index 7 pushes `bus_wdata[7:0]`. `tx_valid` is high while the transmit FIFO holds data, `tx_data` shows the oldest byte, and bytes leave in write order.
- R7: The transmit FIFO holds 128 bytes. Status bit 3 is set at 128, and a write while full is dropped.
- R8: Status bit 2 is high while transmit occupancy is strictly less than the watermark.
- R9: `rx_ready` is high unless the receive FIFO holds 128 bytes. A beat with `rx_valid` and `rx_ready` high is stored. Bit 4 shows a non-empty receive FIFO and bit 5 shows a full one.
- R10: A read of index 8 returns the oldest received byte in bits 7:0 and pops it. On an empty FIFO the read returns 0 and pops nothing.
- R11: `rx_valid` while `rx_ready` is low sets sticky bit 0 and discards the byte.
- R12: `tx_ready` while the transmit FIFO is empty sets sticky bit 6.
- R13: A high `fault_in` in any cycle sets sticky bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read strobe, one word per cycle |
| bus_addr | input | 6 | Byte address; bits 1:0 are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tx_valid | output | 1 | Transmit byte available |
| tx_ready | input | 1 | Shift engine takes a byte |
| tx_data | output | 8 | Oldest transmit byte |
| rx_valid | input | 1 | Received byte offered |
| rx_ready | output | 1 | Receive FIFO has room |
| rx_data | input | 8 | Received byte |
| fault_in | input | 1 | Mode-fault event from the bus pins |
| cfg_word | output | 32 | Configuration register |
| spi_en | output | 1 | Enable bit |
| delay_word | output | 32 | Delay register |
| idle_count | output | 8 | Idle count register |
| irq | output | 1 | Interrupt request |

## Verification
Register contents, mask changes, sticky flags, FIFO levels and the stream outputs all change at the clock edge that samples the stimulus. Because `irq` is combinational from that state, it is due at that same edge. Read data is due one edge after the read strobe. The bench updates a behavioural model at each rising edge from the inputs it drove at the previous falling edge. It compares the outputs at the following falling edge, so every result is checked in the cycle it is due. Directed reads then repeat the key values as fixed literals.

// File: rtl/spireg_pkg.sv
package spireg_pkg;
  localparam int REG_W = 32;
  localparam int IRQ_W = 7;

  // word indices (byte address >> 2)
  localparam int IX_CFG   = 0;
  localparam int IX_STAT  = 1;
  localparam int IX_MSET  = 2;
  localparam int IX_MCLR  = 3;
  localparam int IX_MASK  = 4;
  localparam int IX_EN    = 5;
  localparam int IX_DLY   = 6;
  localparam int IX_TXD   = 7;
  localparam int IX_RXD   = 8;
  localparam int IX_IDLE  = 9;
  localparam int IX_WMARK = 10;

  // interrupt word bit positions
  localparam int B_RXOVF  = 0;
  localparam int B_FAULT  = 1;
  localparam int B_TXLOW  = 2;
  localparam int B_TXFULL = 3;
  localparam int B_RXNE   = 4;
  localparam int B_RXFULL = 5;
  localparam int B_TXUNF  = 6;

  localparam logic [IRQ_W-1:0] STICKY_BITS = 7'b100_0011;

  typedef struct packed {
    logic cfg;
    logic stat;
    logic mset;
    logic mclr;
    logic en;
    logic dly;
    logic txd;
    logic idle;
    logic wmark;
  } wr_strobe_t;
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int DEPTH = 128,
  parameter int W     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic [CNT_W-1:0] cnt;
  logic             do_push, do_pop;

  assign full    = (cnt == CNT_W'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];
  assign count   = cnt;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CNT_W'(DEPTH)) else $error("fifo count beyond depth"); // R7
  AST_FIFO_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n) (push && full && !pop) |=> $stable(cnt)) else $error("push accepted while full"); // R7
  AST_FIFO_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n) (pop && empty && !push) |=> empty) else $error("pop on empty moved state"); // R10
endmodule

// File: rtl/cfg_bank.sv
module cfg_bank
  import spireg_pkg::*;
#(
  parameter int IDLE_W   = 8,
  parameter int WM_W     = 8,
  parameter int WM_RESET = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wr_strobe_t        wr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  cfg_q,
  output logic              en_q,
  output logic [REG_W-1:0]  dly_q,
  output logic [IDLE_W-1:0] idle_q,
  output logic [WM_W-1:0]   wmark_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      en_q    <= 1'b0;
      dly_q   <= '0;
      idle_q  <= '0;
      wmark_q <= WM_W'(WM_RESET);
    end else begin
      if (wr.cfg)   cfg_q   <= wdata;
      if (wr.en)    en_q    <= wdata[0];
      if (wr.dly)   dly_q   <= wdata;
      if (wr.idle)  idle_q  <= wdata[IDLE_W-1:0];
      if (wr.wmark) wmark_q <= wdata[WM_W-1:0];
    end
  end

  AST_WMARK_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !wr.wmark |=> $stable(wmark_q)) else $error("watermark changed without write"); // R2
  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n) wr.cfg |=> cfg_q == $past(wdata)) else $error("config write lost"); // R2
endmodule

// File: rtl/irq_unit.sv
module irq_unit
  import spireg_pkg::*;
#(
  parameter int               N      = IRQ_W,
  parameter logic [N-1:0]     STICKY = STICKY_BITS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic         stat_we,
  input  logic [N-1:0] wdata,
  input  logic [N-1:0] ev_vec,
  input  logic [N-1:0] lvl_vec,
  output logic [N-1:0] status,
  output logic [N-1:0] mask,
  output logic         irq
);
  logic unused_bits;
  assign unused_bits = ^(ev_vec & ~STICKY) ^ ^(lvl_vec & STICKY);

  for (genvar i = 0; i < N; i++) begin : g_bit
    if (STICKY[i]) begin : g_sticky
      logic st;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= 1'b0;
        else        st <= (st & ~(stat_we & wdata[i])) | ev_vec[i];
      end
      assign status[i] = st;
      AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n) ev_vec[i] |=> status[i]) else $error("sticky event lost"); // R4
    end else begin : g_level
      assign status[i] = lvl_vec[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask <= '0;
    else        mask <= (mask | (set_we ? wdata : '0)) & ~(clr_we ? wdata : '0);
  end

  assign irq = |(status & mask);

  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n) set_we |=> (mask & $past(wdata)) == $past(wdata)) else $error("mask set failed"); // R3
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n) clr_we |=> (mask & $past(wdata)) == '0) else $error("mask clear failed"); // R3
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (mask == '0) |-> !irq) else $error("irq with empty mask"); // R5
endmodule

// File: rtl/spi_regfile_irq.sv
module spi_regfile_irq
  import spireg_pkg::*;
#(
  parameter int FIFO_DEPTH = 128,
  parameter int ADDR_W     = 6,
  parameter int IDLE_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  input  logic              fault_in,
  output logic [31:0]       cfg_word,
  output logic              spi_en,
  output logic [31:0]       delay_word,
  output logic [IDLE_W-1:0] idle_count,
  output logic              irq
);
  localparam int IDX_W = ADDR_W - 2;
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  logic [IDX_W-1:0] idx;
  logic             unused_addr;
  assign idx         = bus_addr[ADDR_W-1:2];
  assign unused_addr = ^bus_addr[1:0];

  function automatic logic hit(input logic [IDX_W-1:0] a, input int k);
    return a == IDX_W'(k);
  endfunction

  wr_strobe_t wr;
  always_comb begin
    wr.cfg   = bus_wr && hit(idx, IX_CFG);
    wr.stat  = bus_wr && hit(idx, IX_STAT);
    wr.mset  = bus_wr && hit(idx, IX_MSET);
    wr.mclr  = bus_wr && hit(idx, IX_MCLR);
    wr.en    = bus_wr && hit(idx, IX_EN);
    wr.dly   = bus_wr && hit(idx, IX_DLY);
    wr.txd   = bus_wr && hit(idx, IX_TXD);
    wr.idle  = bus_wr && hit(idx, IX_IDLE);
    wr.wmark = bus_wr && hit(idx, IX_WMARK);
  end

  // configuration registers
  logic [CNT_W-1:0] wmark_q;
  cfg_bank #(.IDLE_W(IDLE_W), .WM_W(CNT_W), .WM_RESET(1)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(wr), .wdata(bus_wdata),
    .cfg_q(cfg_word), .en_q(spi_en), .dly_q(delay_word),
    .idle_q(idle_count), .wmark_q(wmark_q)
  );

  // transmit path
  logic [CNT_W-1:0] tx_count;
  logic             tx_full, tx_empty;
  byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push(wr.txd), .din(bus_wdata[7:0]),
    .pop(tx_ready), .dout(tx_data),
    .count(tx_count), .full(tx_full), .empty(tx_empty)
  );
  assign tx_valid = !tx_empty;

  // receive path
  logic [CNT_W-1:0] unused_rx_count;
  logic             rx_full, rx_empty, rx_pop;
  logic [7:0]       rx_head;
  assign rx_pop = bus_rd && hit(idx, IX_RXD);
  byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push(rx_valid), .din(rx_data),
    .pop(rx_pop), .dout(rx_head),
    .count(unused_rx_count), .full(rx_full), .empty(rx_empty)
  );
  assign rx_ready = !rx_full;

  // interrupt word
  logic [IRQ_W-1:0] ev_vec, lvl_vec, irq_status, irq_mask;
  always_comb begin
    ev_vec           = '0;
    ev_vec[B_RXOVF]  = rx_valid && rx_full;
    ev_vec[B_FAULT]  = fault_in;
    ev_vec[B_TXUNF]  = tx_ready && tx_empty;
    lvl_vec           = '0;
    lvl_vec[B_TXLOW]  = tx_count < wmark_q;
    lvl_vec[B_TXFULL] = tx_full;
    lvl_vec[B_RXNE]   = !rx_empty;
    lvl_vec[B_RXFULL] = rx_full;
  end

  irq_unit #(.N(IRQ_W), .STICKY(STICKY_BITS)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .set_we(wr.mset), .clr_we(wr.mclr), .stat_we(wr.stat),
    .wdata(bus_wdata[IRQ_W-1:0]),
    .ev_vec(ev_vec), .lvl_vec(lvl_vec),
    .status(irq_status), .mask(irq_mask), .irq(irq)
  );

  // read mux and registered read data
  logic [31:0] rd_val;
  always_comb begin
    rd_val = '0;
    if      (hit(idx, IX_CFG))   rd_val = cfg_word;
    else if (hit(idx, IX_STAT))  rd_val = 32'(irq_status);
    else if (hit(idx, IX_MASK))  rd_val = 32'(irq_mask);
    else if (hit(idx, IX_EN))    rd_val = {31'b0, spi_en};
    else if (hit(idx, IX_DLY))   rd_val = delay_word;
    else if (hit(idx, IX_RXD))   rd_val = rx_empty ? '0 : {24'b0, rx_head};
    else if (hit(idx, IX_IDLE))  rd_val = 32'(idle_count);
    else if (hit(idx, IX_WMARK)) rd_val = 32'(wmark_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end

  AST_RX_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n) (rx_pop && rx_empty) |=> bus_rdata == '0) else $error("empty RX read not zero"); // R10
  AST_OVF_SEEN: assert property (@(posedge clk) disable iff (!rst_n) (rx_valid && !rx_ready) |=> irq_status[B_RXOVF]) else $error("overflow not flagged"); // R11
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (tx_valid && !tx_ready) |=> tx_valid && $stable(tx_data)) else $error("tx byte moved while stalled"); // R6
  AST_UNF_SEEN: assert property (@(posedge clk) disable iff (!rst_n) (tx_ready && !tx_valid) |=> irq_status[B_TXUNF]) else $error("underflow not flagged"); // R12
endmodule

// File: tb/sim_spi_regfile_irq.sv
module sim_spi_regfile_irq;
  localparam int D = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [5:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        tx_valid, tx_ready = 0;
  logic [7:0]  tx_data;
  logic        rx_valid = 0, rx_ready;
  logic [7:0]  rx_data = 0;
  logic        fault_in = 0;
  logic [31:0] cfg_word, delay_word;
  logic        spi_en, irq;
  logic [7:0]  idle_count;

  always #2 clk = ~clk; // 250 MHz

  spi_regfile_irq u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .fault_in(fault_in), .cfg_word(cfg_word), .spi_en(spi_en),
    .delay_word(delay_word), .idle_count(idle_count), .irq(irq)
  );

  int n_run = 0, n_fail = 0, cycles = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=0x%0h exp=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  byte unsigned txq[$], rxq[$];
  logic [6:0]  m_mask, m_stk;
  logic [31:0] m_cfg, m_dly, m_rd;
  logic        m_en;
  logic [7:0]  m_idle, m_wm;

  function automatic logic [6:0] m_status();
    return {m_stk[6], rxq.size() == D, rxq.size() != 0, txq.size() == D,
            txq.size() < int'(m_wm), m_stk[1], m_stk[0]};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      txq.delete(); rxq.delete();
      m_mask = 0; m_stk = 0; m_cfg = 0; m_dly = 0; m_rd = 0;
      m_en = 0; m_idle = 0; m_wm = 1;
    end else begin
      int ix, ts, rs;
      logic [6:0] st;
      ix = int'(bus_addr[5:2]);
      ts = txq.size(); rs = rxq.size();
      st = m_status();
      if (bus_rd) begin
        case (ix)
          0: m_rd = m_cfg;
          1: m_rd = 32'(st);
          4: m_rd = 32'(m_mask);
          5: m_rd = {31'b0, m_en};
          6: m_rd = m_dly;
          8: m_rd = (rs > 0) ? 32'(rxq[0]) : 0;
          9: m_rd = 32'(m_idle);
          10: m_rd = 32'(m_wm);
          default: m_rd = 0;
        endcase
      end
      if (bus_wr && ix == 1) m_stk = m_stk & ~(bus_wdata[6:0] & 7'b100_0011);
      if (rx_valid && rs == D) m_stk[0] = 1;
      if (fault_in) m_stk[1] = 1;
      if (tx_ready && ts == 0) m_stk[6] = 1;
      if (bus_rd && ix == 8 && rs > 0) void'(rxq.pop_front());
      if (rx_valid && rs < D) rxq.push_back(rx_data);
      if (tx_ready && ts > 0) void'(txq.pop_front());
      if (bus_wr && ix == 7 && ts < D) txq.push_back(bus_wdata[7:0]);
      if (bus_wr) begin
        case (ix)
          0: m_cfg = bus_wdata;
          2: m_mask = m_mask | bus_wdata[6:0];
          3: m_mask = m_mask & ~bus_wdata[6:0];
          5: m_en = bus_wdata[0];
          6: m_dly = bus_wdata;
          9: m_idle = bus_wdata[7:0];
          10: m_wm = bus_wdata[7:0];
          default: ;
        endcase
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(irq == |(m_status() & m_mask), "R5 irq", 32'(irq), 32'(|(m_status() & m_mask)));
      chk(tx_valid == (txq.size() > 0), "R6 tx_valid", 32'(tx_valid), 32'(txq.size() > 0));
      if (txq.size() > 0) chk(tx_data == txq[0], "R6 tx_data", 32'(tx_data), 32'(txq[0]));
      chk(rx_ready == (rxq.size() < D), "R9 rx_ready", 32'(rx_ready), 32'(rxq.size() < D));
      chk(bus_rdata == m_rd, "R2 rdata", bus_rdata, m_rd);
      chk(cfg_word == m_cfg && delay_word == m_dly && idle_count == m_idle && spi_en == m_en,
          "R2 outputs", cfg_word, m_cfg);
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles >= 20000 && !done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog (all requirements) act=%0d exp=<20000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd_exp(input logic [5:0] a, input logic [31:0] e, input string tag);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    chk(bus_rdata == e, tag, bus_rdata, e);
  endtask

  task automatic rx_put(input logic [7:0] d);
    rx_valid = 1; rx_data = d;
    @(negedge clk);
    rx_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    rd_exp(6'h04, 32'h04, "R1 status");
    rd_exp(6'h10, 32'h00, "R1 mask");
    rd_exp(6'h28, 32'h01, "R1 watermark");
    chk(irq == 0, "R1 irq", 32'(irq), 0);

    // R2: read/write registers, write-only and unmapped reads
    wr(6'h00, 32'hA5A5_1234);
    wr(6'h18, 32'h0000_BEEF);
    wr(6'h24, 32'h3C);
    wr(6'h14, 32'h1);
    rd_exp(6'h00, 32'hA5A5_1234, "R2 cfg");
    rd_exp(6'h18, 32'h0000_BEEF, "R2 delay");
    rd_exp(6'h24, 32'h3C, "R2 idle");
    rd_exp(6'h14, 32'h1, "R2 enable");
    rd_exp(6'h1C, 32'h0, "R2 txdata read");
    rd_exp(6'h08, 32'h0, "R2 maskset read");
    rd_exp(6'h2C, 32'h0, "R2 unmapped");

    // R3: mask set/clear
    wr(6'h08, 32'h14);
    rd_exp(6'h10, 32'h14, "R3 set");
    wr(6'h0C, 32'h04);
    rd_exp(6'h10, 32'h10, "R3 clear");
    wr(6'h08, 32'h00);
    rd_exp(6'h10, 32'h10, "R3 zero write");

    // R8 / R6: watermark and ordering
    wr(6'h28, 32'd3);
    wr(6'h1C, 32'h11);
    wr(6'h1C, 32'h22);
    rd_exp(6'h04, 32'h04, "R8 below");
    wr(6'h1C, 32'h33);
    rd_exp(6'h04, 32'h00, "R8 at level");
    for (int i = 0; i < 3; i++) begin
      chk(tx_data == 8'h11 * (i + 1), "R6 order", 32'(tx_data), 32'(8'h11 * (i + 1)));
      tx_ready = 1;
      @(negedge clk);
      tx_ready = 0;
    end
    wr(6'h28, 32'd1);

    // R7: full transmit FIFO, dropped write; R12 underflow
    for (int i = 0; i < D; i++) wr(6'h1C, 32'(i));
    rd_exp(6'h04, 32'h08, "R7 full");
    wr(6'h1C, 32'hEE);
    for (int i = 0; i < D; i++) begin
      chk(tx_valid && tx_data == 8'(i), "R7 drain", 32'(tx_data), 32'(i));
      tx_ready = 1;
      @(negedge clk);
    end
    chk(tx_valid == 0, "R7 dropped byte absent", 32'(tx_valid), 0);
    @(negedge clk);
    tx_ready = 0;
    rd_exp(6'h04, 32'h44, "R12 underflow");
    wr(6'h04, 32'h40);
    rd_exp(6'h04, 32'h04, "R4 clear underflow");

    // R9 / R10: receive path
    rx_put(8'hA1);
    rx_put(8'hB2);
    rd_exp(6'h04, 32'h14, "R9 not empty");
    chk(irq == 1, "R5 irq on rx", 32'(irq), 1);
    rd_exp(6'h20, 32'hA1, "R10 pop1");
    rd_exp(6'h20, 32'hB2, "R10 pop2");
    rd_exp(6'h20, 32'h00, "R10 empty read");
    chk(irq == 0, "R5 irq low", 32'(irq), 0);
    for (int i = 0; i < D; i++) rx_put(8'(i) ^ 8'h5A);
    chk(rx_ready == 0, "R9 full stalls", 32'(rx_ready), 0);
    rd_exp(6'h04, 32'h34, "R9 full");
    rx_put(8'hFF);
    rd_exp(6'h04, 32'h35, "R11 overflow");
    for (int i = 0; i < D; i++) rd_exp(6'h20, 32'(8'(i) ^ 8'h5A), "R10 order");
    rd_exp(6'h20, 32'h00, "R11 byte discarded");
    wr(6'h04, 32'h01);
    rd_exp(6'h04, 32'h04, "R4 clear overflow");

    // R13 / R4 / R5: fault, level bits immune, set beats clear
    fault_in = 1;
    @(negedge clk);
    fault_in = 0;
    rd_exp(6'h04, 32'h06, "R13 fault");
    wr(6'h08, 32'h02);
    chk(irq == 1, "R5 fault irq", 32'(irq), 1);
    rx_put(8'h77);
    wr(6'h04, 32'h3C);
    rd_exp(6'h04, 32'h16, "R4 level immune");
    fault_in = 1;
    wr(6'h04, 32'h02);
    fault_in = 0;
    rd_exp(6'h04, 32'h16, "R4 set wins");
    wr(6'h04, 32'h02);
    rd_exp(6'h04, 32'h14, "R4 clear fault");
    chk(irq == 1, "R5 rx irq", 32'(irq), 1);
    wr(6'h0C, 32'h10);
    chk(irq == 0, "R5 masked", 32'(irq), 0);
    rd_exp(6'h20, 32'h77, "R10 last");

    repeat (2) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule